// File: doc/BRIEF.md
# Fine-Grain Warp Issue Scheduler

This block decides which hardware thread context, or warp, issues its next instruction. It holds a set of warp contexts and can pick a different one at every issue boundary. Candidates are taken in rotating order, and any context that is not valid or is flagged as stalled is passed over. Switching from one warp to another costs no flush and leaves no idle cycle.

Each warp instruction covers a group of threads that is wider than the execution datapath. A grant therefore occupies a fixed beat of several consecutive cycles, one cycle for each lane group. With the default sizing (32 threads on 8 lanes) a beat lasts 4 cycles. During the beat the block holds the granted warp number steady and steps a lane-group index, which downstream logic uses to pass the threads through the lanes one group at a time. A new selection is made only on the last cycle of a beat, or on any cycle while the block is idle.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `issue_strobe` and `issue_busy` are 0, and `lane_grp` and `issue_warp` are 0.
- R2: A warp is eligible only if its `warp_valid` bit is 1 and its `warp_stall` bit is 0. Only an eligible warp is ever granted.
- R3: The rotating search starts at warp 0 after reset. After each grant it starts at the warp numbered one above the granted warp, and it wraps from the highest warp number back to warp 0.
- R4: Each grant is a beat of THREADS/LANES cycles (4 by default). `issue_busy` is high for the whole beat. `lane_grp` counts 0, 1, 2, 3 across the beat. `issue_strobe` is high only in the first cycle of the beat.
- R5: `issue_warp` keeps the same value for every cycle of a beat.
- R6: If a warp is eligible on the last cycle of a beat, the next beat begins in the following cycle, with no gap.
- R7: At an issue boundary with no eligible warp, no strobe is raised and `issue_busy` goes low. The search is repeated every cycle, and a warp that becomes eligible gets its strobe one cycle later.
- R8: Raising a warp's stall bit during its beat does not shorten the beat or change it.
- R9: If one warp is the only eligible warp, it is granted again in back-to-back beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_valid | input | NUM_WARPS | One bit per warp: the warp holds work |
| warp_stall | input | NUM_WARPS | One bit per warp: the warp cannot issue now |
| issue_strobe | output | 1 | One-cycle pulse at the start of a beat |
| issue_busy | output | 1 | High during every cycle of a beat |
| issue_warp | output | $clog2(NUM_WARPS) | Warp number granted for the current beat |
| lane_grp | output | $clog2(THREADS/LANES) | Lane group being sequenced in this cycle |

## Verification
The checker watches several properties on every cycle. A strobe always coincides with lane group 0 and busy. Inside a beat the lane group steps by one, the warp number holds and no second strobe appears. Every strobe names a warp that was eligible at the selecting edge. A boundary with nothing eligible produces no strobe. The rotating order is only shown by the bench's scenarios: the wrap past the highest warp number, the skipping of stalled warps, back-to-back repeats of a single warp, and a stall raised in the middle of a beat.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // cycles one warp instruction occupies: thread groups over datapath lanes
  function automatic int beat_cycles(int threads, int lanes);
    return (threads + lanes - 1) / lanes;
  endfunction

  // width that still works for a count of one
  function automatic int idx_width(int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int NUM   = 24,
  parameter int IDX_W = 5
) (
  input  logic [NUM-1:0]   elig,
  input  logic [IDX_W-1:0] start_at,
  output logic [IDX_W-1:0] pick,
  output logic             found
);

  // walk offsets from far to near so the nearest eligible warp wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = NUM - 1; k >= 0; k--) begin
      int idx;
      idx = int'(start_at) + k;
      if (idx >= NUM) idx = idx - NUM;
      if (elig[idx]) begin
        pick  = IDX_W'(idx);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/warp_beat_ctr.sv
module warp_beat_ctr #(
  parameter int BEAT  = 4,
  parameter int GRP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [GRP_W-1:0] grp,
  output logic             last
);

  logic             busy_nxt;
  logic [GRP_W-1:0] grp_nxt;

  assign last = busy && (grp == GRP_W'(BEAT - 1));

  always_comb begin
    busy_nxt = busy;
    grp_nxt  = grp;
    if (start) begin
      busy_nxt = 1'b1;
      grp_nxt  = '0;
    end else if (last) begin
      busy_nxt = 1'b0;
      grp_nxt  = '0;
    end else if (busy) begin
      grp_nxt  = grp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      grp  <= '0;
    end else begin
      busy <= busy_nxt;
      grp  <= grp_nxt;
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int THREADS   = 32,
  parameter int LANES     = 8,
  localparam int BEAT     = beat_cycles(THREADS, LANES),
  localparam int ID_W     = idx_width(NUM_WARPS),
  localparam int GRP_W    = idx_width(BEAT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_valid,
  input  logic [NUM_WARPS-1:0] warp_stall,
  output logic                 issue_strobe,
  output logic                 issue_busy,
  output logic [ID_W-1:0]      issue_warp,
  output logic [GRP_W-1:0]     lane_grp
);

  logic [NUM_WARPS-1:0] elig;
  logic [ID_W-1:0]      search_ptr, search_ptr_nxt;
  logic [ID_W-1:0]      pick;
  logic                 found;
  logic                 beat_last;
  logic                 boundary;
  logic                 grant;
  logic [ID_W-1:0]      warp_nxt;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_elig
    assign elig[g] = warp_valid[g] & ~warp_stall[g];
  end

  warp_rr_pick #(
    .NUM   (NUM_WARPS),
    .IDX_W (ID_W)
  ) u_pick (
    .elig     (elig),
    .start_at (search_ptr),
    .pick     (pick),
    .found    (found)
  );

  warp_beat_ctr #(
    .BEAT  (BEAT),
    .GRP_W (GRP_W)
  ) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .start (grant),
    .busy  (issue_busy),
    .grp   (lane_grp),
    .last  (beat_last)
  );

  assign boundary = !issue_busy || beat_last;
  assign grant    = boundary && found;

  always_comb begin
    search_ptr_nxt = search_ptr;
    warp_nxt       = issue_warp;
    if (grant) begin
      warp_nxt       = pick;
      search_ptr_nxt = (pick == ID_W'(NUM_WARPS - 1)) ? '0 : pick + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      search_ptr   <= '0;
      issue_warp   <= '0;
      issue_strobe <= 1'b0;
    end else begin
      search_ptr   <= search_ptr_nxt;
      issue_warp   <= warp_nxt;
      issue_strobe <= grant;
    end
  end

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 24,
  parameter int BEAT      = 4,
  parameter int ID_W      = 5,
  parameter int GRP_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] warp_valid,
  input logic [NUM_WARPS-1:0] warp_stall,
  input logic                 issue_strobe,
  input logic                 issue_busy,
  input logic [ID_W-1:0]      issue_warp,
  input logic [GRP_W-1:0]     lane_grp
);

  logic [NUM_WARPS-1:0] elig_q;
  logic                 at_boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_q <= '0;
    else        elig_q <= warp_valid & ~warp_stall;
  end

  assign at_boundary = !issue_busy || (lane_grp == GRP_W'(BEAT - 1));

  // R4: a strobe marks the first lane group of a busy beat
  p_strobe_opens_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_strobe |-> (issue_busy && lane_grp == '0));

  // R4, R5, R8: inside a beat the group steps, warp holds, no new strobe
  p_beat_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_busy && lane_grp != GRP_W'(BEAT - 1)) |=>
      (issue_busy && !issue_strobe && $stable(issue_warp) &&
       lane_grp == GRP_W'($past(lane_grp) + 1'b1)));

  // R2: the granted warp was eligible at the selecting edge
  p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_strobe |-> elig_q[issue_warp]);

  // R7: nothing eligible at a boundary means idle and no strobe
  p_idle_when_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && (warp_valid & ~warp_stall) == '0) |=>
      (!issue_strobe && !issue_busy));

  // R6: something eligible at a boundary opens a beat next cycle
  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && (warp_valid & ~warp_stall) != '0) |=> issue_strobe);

  // R1: idle keeps the lane group at zero
  p_idle_grp_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_busy |-> (lane_grp == '0 && !issue_strobe));

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS (NUM_WARPS),
  .BEAT      (BEAT),
  .ID_W      (ID_W),
  .GRP_W     (GRP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .warp_valid   (warp_valid),
  .warp_stall   (warp_stall),
  .issue_strobe (issue_strobe),
  .issue_busy   (issue_busy),
  .issue_warp   (issue_warp),
  .lane_grp     (lane_grp)
);

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;

  localparam int CLK_PERIOD = 10;
  localparam int NW         = 24;

  logic          clk;
  logic          rst_n;
  logic [NW-1:0] warp_valid;
  logic [NW-1:0] warp_stall;
  logic          issue_strobe;
  logic          issue_busy;
  logic [4:0]    issue_warp;
  logic [1:0]    lane_grp;

  int checks;
  int errors;

  warp_issue_sched i_warp_issue_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .warp_valid   (warp_valid),
    .warp_stall   (warp_stall),
    .issue_strobe (issue_strobe),
    .issue_busy   (issue_busy),
    .issue_warp   (issue_warp),
    .lane_grp     (lane_grp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // strobe, busy, lane group and warp checked together
  task automatic expect_out(string tag, int stb, int bsy, int grp, int wid);
    expect_eq(tag, "issue_strobe", int'(issue_strobe), stb);
    expect_eq(tag, "issue_busy", int'(issue_busy), bsy);
    expect_eq(tag, "lane_grp", int'(lane_grp), grp);
    if (bsy != 0) expect_eq(tag, "issue_warp", int'(issue_warp), wid);
  endtask

  task automatic do_reset();
    rst_n      = 1'b0;
    warp_valid = '0;
    warp_stall = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: reset values, held and in the cycle after release
  task automatic t_reset();
    rst_n      = 1'b0;
    warp_valid = '0;
    warp_stall = '0;
    @(negedge clk);
    expect_out("R1", 0, 0, 0, 0);
    expect_eq("R1", "issue_warp", int'(issue_warp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 0, 0, 0, 0);
    expect_eq("R1", "issue_warp", int'(issue_warp), 0);
  endtask

  // R4, R5, R6, R9: lone warp repeats in back-to-back beats
  task automatic t_single_warp();
    do_reset();
    warp_valid[5] = 1'b1;
    @(negedge clk);
    expect_out("R4", 1, 1, 0, 5);
    for (int c = 1; c < 4; c++) begin
      @(negedge clk);
      expect_out("R5", 0, 1, c, 5);
    end
    @(negedge clk);
    expect_out("R9", 1, 1, 0, 5);
    warp_valid = '0;
    repeat (3) @(negedge clk);
    expect_eq("R4", "lane_grp end of beat", int'(lane_grp), 3);
    @(negedge clk);
    expect_out("R7", 0, 0, 0, 0);
  endtask

  // R3, R6: rotation over 2, 7, 23 and wrap back to 2
  task automatic t_rotate();
    int order[4] = '{2, 7, 23, 2};
    do_reset();
    warp_valid[2]  = 1'b1;
    warp_valid[7]  = 1'b1;
    warp_valid[23] = 1'b1;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      expect_out("R3", 1, 1, 0, order[b]);
      repeat (3) @(negedge clk);
      expect_out("R6", 0, 1, 3, order[b]);
    end
  endtask

  // R2: stalled and invalid warps are passed over
  task automatic t_skip_stalled();
    do_reset();
    warp_valid = '1;
    warp_stall = NW'(24'h00000F);
    @(negedge clk);
    expect_out("R2", 1, 1, 0, 4);
    warp_stall[5] = 1'b1;
    repeat (4) @(negedge clk);
    expect_out("R2", 1, 1, 0, 6);
    warp_valid = NW'(24'h000080);
    warp_stall = '0;
    repeat (4) @(negedge clk);
    expect_out("R2", 1, 1, 0, 7);
  endtask

  // R7: idle with none eligible, then grant one cycle after eligibility
  task automatic t_none_eligible();
    do_reset();
    repeat (3) begin
      @(negedge clk);
      expect_out("R7", 0, 0, 0, 0);
    end
    warp_valid = '1;
    warp_stall = '1;
    repeat (3) begin
      @(negedge clk);
      expect_out("R7", 0, 0, 0, 0);
    end
    warp_stall[9] = 1'b0;
    @(negedge clk);
    expect_out("R7", 1, 1, 0, 9);
  endtask

  // R8: stall raised mid-beat does not cut the beat short
  task automatic t_stall_mid_beat();
    do_reset();
    warp_valid[3] = 1'b1;
    @(negedge clk);
    expect_out("R8", 1, 1, 0, 3);
    warp_stall[3] = 1'b1;
    for (int c = 1; c < 4; c++) begin
      @(negedge clk);
      expect_out("R8", 0, 1, c, 3);
    end
    @(negedge clk);
    expect_out("R8", 0, 0, 0, 0);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    warp_valid = '0;
    warp_stall = '0;
    t_reset();
    t_single_warp();
    t_rotate();
    t_skip_stalled();
    t_none_eligible();
    t_stall_mid_beat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule